// File: doc/BRIEF.md
# Temperature-Banded Partial-Window Refresh Scheduler

This block decides when a self-refreshing DRAM core should refresh a row, and which row that is. It has a free-running slot timer and a row pointer. When refresh is enabled and the selected window is not empty, the block issues a one-cycle request strobe once per refresh interval. The row address is valid in the same cycle as the strobe.

The interval comes from a two-bit temperature setting. The four settings cover the bands up to roughly +15, +45, +70 and +85 °C. The hottest setting refreshes most often, and each cooler setting doubles the gap of the next hotter one. A three-bit size code limits refresh to the full array, half of it, a quarter, an eighth, or no rows at all. A direction bit anchors that window at the lowest or at the highest row address. Rows outside the window never appear on the request. The DRAM cell model, arbitration against user accesses and temperature sensing sit outside this block.

Top module: `refresh_scheduler`

## Requirements
- R1: During reset and in the first cycle after reset is released, `ref_req` is 0.
- R2: While the block is active, successive strobes are exactly `BASE_GAP << (3 - temp_sel)` cycles apart. Code 3 is the hottest band (+85 °C), code 2 is +70 °C, code 1 is +45 °C and code 0 is +15 °C.
- R3: `win_sel` sets the window length to `2**ROW_BITS >> win_sel` rows for codes 0 to 3 (full, half, quarter, eighth). Any code with bit 2 set selects an empty window.
- R4: With `win_top` = 0, the window covers rows 0 to length−1.
- R5: With `win_top` = 1, the window covers rows `2**ROW_BITS` − length to `2**ROW_BITS` − 1.
- R6: Successive strobes step the row by one through the window and wrap back to the window's first row after its last row.
- R7: A change of `temp_sel`, `win_sel` or `win_top` takes effect at the next strobe. If the pointer lies beyond a shrunken window, that strobe goes to the window's first row.
- R8: While `refresh_en` is 0, or while the window is empty, no strobe is issued. When the block becomes active again, the first strobe follows on the next cycle and addresses the window's first row.
- R9: Each strobe lasts exactly one cycle, and `ref_row` carries the addressed row in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_en | input | 1 | Allows refresh requests |
| temp_sel | input | 2 | Temperature band, 3 = hottest |
| win_sel | input | 3 | Window size: 0 full, 1 half, 2 quarter, 3 eighth, 4 to 7 none |
| win_top | input | 1 | 0 = window at the low end, 1 = window at the high end |
| ref_req | output | 1 | One-cycle refresh request strobe |
| ref_row | output | ROW_BITS | Row address valid with `ref_req` |

## Verification
The bench targets the pointer wrap at the end of an eighth-size window. A design with an off-by-one error there would run onto a row outside the window or skip the first row. It also shrinks the window while the pointer sits deep in the full array, where a design that does not clamp the pointer would request a row past the window's end. The bench switches temperature bands while a gap is in progress, so a design that reloads its timer at the wrong moment would stretch or shorten the very next gap. It also toggles enable and the empty-window codes; a design that keeps its old timer or pointer would issue a stray strobe, or resume at a row other than the window's first.

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int ROW_BITS = 6,
  parameter int BASE_GAP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refresh_en,
  input  logic [1:0]          temp_sel,
  input  logic [2:0]          win_sel,
  input  logic                win_top,
  output logic                ref_req,
  output logic [ROW_BITS-1:0] ref_row
);
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int GAP_BITS = $clog2(BASE_GAP * 8) + 1;
  localparam int PW       = ROW_BITS + 1;

  logic            active;
  logic [PW-1:0]   win_len, win_lo, win_hi;
  logic [PW-1:0]   ptr, ptr_eff, ptr_nxt;
  logic [GAP_BITS-1:0] gap, cnt;

  assign active  = refresh_en && !win_sel[2];
  assign win_len = PW'(ROWS) >> win_sel[1:0];
  assign win_lo  = win_top ? PW'(ROWS) - win_len : '0;
  assign win_hi  = win_lo + win_len - PW'(1);
  assign gap     = GAP_BITS'(BASE_GAP) << (2'd3 - temp_sel);
  assign ptr_eff = (ptr >= win_len) ? '0 : ptr;
  assign ptr_nxt = (ptr_eff + PW'(1) == win_len) ? '0 : ptr_eff + PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      ptr     <= '0;
      ref_req <= 1'b0;
      ref_row <= '0;
    end else if (!active) begin
      cnt     <= '0;
      ptr     <= '0;
      ref_req <= 1'b0;
    end else if (cnt == '0) begin
      ref_req <= 1'b1;
      ref_row <= ROW_BITS'(win_lo + ptr_eff);
      cnt     <= gap - GAP_BITS'(1);
      ptr     <= ptr_nxt;
    end else begin
      ref_req <= 1'b0;
      cnt     <= cnt - GAP_BITS'(1);
    end
  end

  initial assert (BASE_GAP >= 2 && ROW_BITS >= 3);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |=> !ref_req);

  assert_row_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ({1'b0, ref_row} >= $past(win_lo) && {1'b0, ref_row} <= $past(win_hi)));

  assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |=> !ref_req);

  assert_quiet_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_sel[2] |=> !ref_req);
endmodule

// File: tb/refresh_scheduler_tb_top.sv
module refresh_scheduler_tb_top;
  localparam int RB   = 6;
  localparam int BG   = 4;
  localparam int NROW = 1 << RB;

  logic clk = 1'b0, rst_n = 1'b0, refresh_en = 1'b0, win_top = 1'b0;
  logic [1:0] temp_sel = 2'd3;
  logic [2:0] win_sel = 3'd0;
  logic ref_req;
  logic [RB-1:0] ref_row;

  int n_vec = 0, n_bad = 0;
  int m_wait = 0, m_off = 0, exp_row = 0;
  bit exp_req = 0;

  refresh_scheduler #(.ROW_BITS(RB), .BASE_GAP(BG)) dut_i (
    .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .temp_sel(temp_sel),
    .win_sel(win_sel), .win_top(win_top), .ref_req(ref_req), .ref_row(ref_row));

  always #5 clk = ~clk;

  function automatic int band_gap(input int code);
    return BG * (1 << (3 - code));
  endfunction

  function automatic int win_length(input int code);
    return (code >= 4) ? 0 : (NROW >> code);
  endfunction

  task automatic step(input string tag);
    @(posedge clk);
    if (!(refresh_en && win_sel < 4)) begin
      exp_req = 0; m_wait = 0; m_off = 0;
    end else if (m_wait == 0) begin
      int len = win_length(win_sel);
      if (m_off >= len) m_off = 0;
      exp_req = 1;
      exp_row = (win_top ? NROW - len : 0) + m_off;
      m_off   = (m_off + 1) % len;
      m_wait  = band_gap(temp_sel) - 1;
    end else begin
      exp_req = 0;
      m_wait--;
    end
    @(negedge clk);
    n_vec++;
    if (ref_req !== exp_req) begin
      n_bad++;
      $display("FAIL %s: ref_req=%0b expected %0b at %0t", tag, ref_req, exp_req, $time);
    end else if (exp_req && ref_row !== exp_row[RB-1:0]) begin
      n_bad++;
      $display("FAIL %s: ref_row=%0d expected %0d at %0t", tag, ref_row, exp_row, $time);
    end
  endtask

  task automatic run(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) step(tag);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run incomplete, expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    n_vec++;
    if (ref_req !== 1'b0) begin
      n_bad++; $display("FAIL R1: ref_req=%0b expected 0 in reset", ref_req);
    end
    rst_n = 1'b1;
    run(5, "R1");
    // R3 / R4: each window size, anchored low
    refresh_en = 1'b1;
    for (int s = 0; s < 4; s++) begin win_sel = 3'(s); run(300, "R3"); end
    // R6: wrap inside an eighth window
    win_sel = 3'd3; run(120, "R6");
    // R5: anchored high
    win_top = 1'b1;
    for (int s = 0; s < 4; s++) begin win_sel = 3'(s); run(200, "R5"); end
    win_top = 1'b0;
    // R2: every band
    win_sel = 3'd0;
    for (int t = 0; t < 4; t++) begin temp_sel = 2'(t); run(260, "R2"); end
    // R7: shrink window with pointer deep in array; band change mid-gap
    temp_sel = 2'd3; run(150, "R7");
    win_sel = 3'd3; run(3, "R7");
    temp_sel = 2'd0; run(80, "R7");
    temp_sel = 2'd3; win_top = 1'b1; run(60, "R7");
    // R8: disabled and empty window, then resume
    refresh_en = 1'b0; run(60, "R8");
    refresh_en = 1'b1; run(40, "R8");
    win_sel = 3'd5; run(60, "R8");
    win_sel = 3'd7; run(20, "R8");
    win_sel = 3'd2; run(40, "R8");
    // R9: random mix
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 39) == 0) temp_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 59) == 0) win_sel = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 79) == 0) win_top = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 149) == 0) refresh_en = ~refresh_en;
      step("R9");
    end
    finish_up();
  end
endmodule